// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block is the host-side register file of a four-channel DMA controller. A host reaches it through an 8-bit I/O port bus with a 4-bit port offset. For each channel it holds a 16-bit address and a 16-bit count, each with a base and a current copy. Because the bus is only 8 bits wide, a 16-bit value moves as two byte accesses to the same port. A shared byte pointer steers each access to the low byte or the high byte.

The block also holds per-channel transfer modes, the channel masks, the software request bits and a command byte. It reports terminal-count and request status, and it accepts master-clear and clear-mask strobes. A transfer engine beside the block reads the current address and count outputs. The engine writes back updated values over a load port, which has a valid strobe and no ready because it always accepts. The engine also signals terminal count, and when autoinitialize is enabled this reloads the current copies from the base copies.

Software loads a count as the number of transfers minus one: 0x0000 means one transfer and 0xFFFF means 65536. The block stores the value exactly as written. Bus reads are combinational in the cycle that `bus_rd` is high. Their side effects, a pointer toggle or a status clear, take place at the closing clock edge. `bus_wr` and `bus_rd` are never high together.

Top module: `dma_regbank`

## Requirements
- R1: After reset all four masks are set, and the command byte, software requests, modes, terminal-count bits, addresses and counts are zero. The byte pointer selects the low byte.
- R2: Channel n's address is at offset 2n and its count at offset 2n+1 (n = 0..3). A write loads the selected byte into both the base and the current copy. A read returns that byte of the current copy.
- R3: The byte pointer toggles on every read or write to offsets 0x0 to 0x7. The pointer is 0 for the low byte and 1 for the high byte. A write of any value to 0xC returns it to the low byte.
- R4: A cycle with `eng_ld_valid` high loads `eng_ld_addr` and `eng_ld_cnt` into the current copies of channel `eng_ld_ch`. The base copies are left unchanged.
- R5: A write to 0xA selects a channel with bits 1:0. Bit 2 set masks that channel and bit 2 clear unmasks it. The other masks are unchanged.
- R6: A write to 0xF loads `ch_mask` from bits 3:0 of the data. A write to 0xE clears all four masks.
- R7: A write to 0xB selects a channel with bits 1:0 and stores bits 7:2 as that channel's 6-bit mode on `ch_mode[6n+5:6n]`. The other channels keep their modes.
- R8: A write to 0x8 loads `cmd_reg`. A read of 0xD returns 0x00. Reads of the write-only offsets 0x9 to 0xC, 0xE and 0xF also return 0x00.
- R9: A read of 0x8 returns the requests in bits 7:4 and the terminal-count bits in bits 3:0. The requests are `eng_dreq` OR'd with the software request bits. A terminal-count bit is set by a pulse on `eng_tc` and holds until a status read clears it. A pulse that arrives in the same cycle as the read is kept.
- R10: A write to 0x9 selects a channel with bits 1:0. Bit 2 sets or clears that channel's software request, which appears on `sw_req`.
- R11: A write to 0xD (master clear) sets all masks and clears the command byte, the software requests, the terminal-count bits and the byte pointer.
- R12: An `eng_tc` pulse on a channel whose mode bit 2 (written data bit 4) is set reloads its current address and count from the base copies. Without that bit, the current copies are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_off | input | 4 | Port offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| eng_ld_valid | input | 1 | Engine update of the current copies, always accepted |
| eng_ld_ch | input | 2 | Channel being updated |
| eng_ld_addr | input | 16 | New current address |
| eng_ld_cnt | input | 16 | New current count |
| eng_tc | input | 4 | Per-channel terminal-count pulse |
| eng_dreq | input | 4 | Per-channel hardware request level |
| ch_mask | output | 4 | Per-channel mask |
| ch_mode | output | 24 | Per-channel 6-bit mode, channel n at bits 6n+5:6n |
| cmd_reg | output | 8 | Command byte |
| sw_req | output | 4 | Software request bits |
| cur_addr | output | 64 | Current addresses, channel n at bits 16n+15:16n |
| cur_cnt | output | 64 | Current counts, channel n at bits 16n+15:16n |

## Verification
The bound checker checks, on every write, the one-cycle effects of the control offsets. These are the single-channel mask, all-mask and clear-mask writes, mode steering by channel number, the command load and the outcome of master clear. The bench scenarios cover behaviour that depends on history. This includes byte-pointer sequencing across several accesses, the recovery of a half-finished 16-bit write after a pointer clear, and the read-to-clear status with sticky terminal-count bits. It also includes the interaction of engine loads, terminal count and autoinitialize reload on the current copies.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int DW     = 8;
  localparam int NCH    = 4;
  localparam int CHW    = $clog2(NCH);
  localparam int VW     = 2 * DW;
  localparam int OFF_W  = 4;
  localparam int MODE_W = DW - CHW;
  localparam int AUTO_BIT = 2;

  localparam logic [OFF_W-1:0] OFF_CMD     = 4'h8;
  localparam logic [OFF_W-1:0] OFF_REQ     = 4'h9;
  localparam logic [OFF_W-1:0] OFF_SMASK   = 4'hA;
  localparam logic [OFF_W-1:0] OFF_MODE    = 4'hB;
  localparam logic [OFF_W-1:0] OFF_CLRPTR  = 4'hC;
  localparam logic [OFF_W-1:0] OFF_MCLR    = 4'hD;
  localparam logic [OFF_W-1:0] OFF_CLRMASK = 4'hE;
  localparam logic [OFF_W-1:0] OFF_AMASK   = 4'hF;
endpackage

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
  import dma_rb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_addr,
  input  logic          we_cnt,
  input  logic          hi_sel,
  input  logic [DW-1:0] wdata,
  input  logic          eng_ld,
  input  logic [VW-1:0] eng_addr,
  input  logic [VW-1:0] eng_cnt,
  input  logic          reload,
  output logic [VW-1:0] cur_addr,
  output logic [VW-1:0] cur_cnt
);
  logic [VW-1:0] base_addr, base_cnt;

  function automatic logic [VW-1:0] put_byte(input logic [VW-1:0] v,
                                             input logic hi,
                                             input logic [DW-1:0] b);
    logic [VW-1:0] r;
    r = v;
    if (hi) r[VW-1:DW] = b;
    else    r[DW-1:0]  = b;
    return r;
  endfunction

  // Host byte write has priority, then autoinit reload, then engine update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (we_addr) begin
      base_addr <= put_byte(base_addr, hi_sel, wdata);
      cur_addr  <= put_byte(cur_addr, hi_sel, wdata);
    end else if (reload) begin
      cur_addr  <= base_addr;
    end else if (eng_ld) begin
      cur_addr  <= eng_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_cnt <= '0;
      cur_cnt  <= '0;
    end else if (we_cnt) begin
      base_cnt <= put_byte(base_cnt, hi_sel, wdata);
      cur_cnt  <= put_byte(cur_cnt, hi_sel, wdata);
    end else if (reload) begin
      cur_cnt  <= base_cnt;
    end else if (eng_ld) begin
      cur_cnt  <= eng_cnt;
    end
  end
endmodule

// File: rtl/dma_rb_ctrl.sv
module dma_rb_ctrl
  import dma_rb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [OFF_W-1:0]      bus_off,
  input  logic [DW-1:0]         bus_wdata,
  input  logic [NCH-1:0]        eng_tc,
  input  logic [NCH-1:0]        eng_dreq,
  output logic                  ptr_hi,
  output logic [NCH-1:0]        ch_mask,
  output logic [NCH*MODE_W-1:0] ch_mode,
  output logic [DW-1:0]         cmd_reg,
  output logic [NCH-1:0]        sw_req,
  output logic [DW-1:0]         status,
  output logic [NCH-1:0]        reload
);
  logic [MODE_W-1:0] mode_q [NCH];
  logic [NCH-1:0]    tc_q;
  logic [CHW-1:0]    wsel;
  logic              chan_acc, mclr, stat_rd;

  assign wsel     = bus_wdata[CHW-1:0];
  assign chan_acc = (bus_wr || bus_rd) && !bus_off[OFF_W-1];
  assign mclr     = bus_wr && bus_off == OFF_MCLR;
  assign stat_rd  = bus_rd && bus_off == OFF_CMD;
  assign status   = {eng_dreq | sw_req, tc_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ptr_hi <= 1'b0;
    else if (mclr || (bus_wr && bus_off == OFF_CLRPTR)) ptr_hi <= 1'b0;
    else if (chan_acc)                            ptr_hi <= ~ptr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_mask <= '1;
      cmd_reg <= '0;
      sw_req  <= '0;
    end else if (mclr) begin
      ch_mask <= '1;
      cmd_reg <= '0;
      sw_req  <= '0;
    end else if (bus_wr) begin
      case (bus_off)
        OFF_CMD:     cmd_reg       <= bus_wdata;
        OFF_REQ:     sw_req[wsel]  <= bus_wdata[CHW];
        OFF_SMASK:   ch_mask[wsel] <= bus_wdata[CHW];
        OFF_CLRMASK: ch_mask       <= '0;
        OFF_AMASK:   ch_mask       <= bus_wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tc_q <= '0;
    else if (mclr)    tc_q <= '0;
    else if (stat_rd) tc_q <= eng_tc;
    else              tc_q <= tc_q | eng_tc;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[n] <= '0;
      else if (bus_wr && bus_off == OFF_MODE && wsel == CHW'(n))
        mode_q[n] <= bus_wdata[DW-1:CHW];
    end
    assign ch_mode[n*MODE_W +: MODE_W] = mode_q[n];
    assign reload[n] = eng_tc[n] && mode_q[n][AUTO_BIT];
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_rb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [OFF_W-1:0]      bus_off,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic                  eng_ld_valid,
  input  logic [CHW-1:0]        eng_ld_ch,
  input  logic [VW-1:0]         eng_ld_addr,
  input  logic [VW-1:0]         eng_ld_cnt,
  input  logic [NCH-1:0]        eng_tc,
  input  logic [NCH-1:0]        eng_dreq,
  output logic [NCH-1:0]        ch_mask,
  output logic [NCH*MODE_W-1:0] ch_mode,
  output logic [DW-1:0]         cmd_reg,
  output logic [NCH-1:0]        sw_req,
  output logic [NCH*VW-1:0]     cur_addr,
  output logic [NCH*VW-1:0]     cur_cnt
);
  logic           ptr_hi;
  logic [DW-1:0]  status;
  logic [NCH-1:0] reload;
  logic [VW-1:0]  ca [NCH];
  logic [VW-1:0]  cc [NCH];

  dma_rb_ctrl u_ctrl (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_off, .bus_wdata,
    .eng_tc, .eng_dreq, .ptr_hi, .ch_mask, .ch_mode, .cmd_reg,
    .sw_req, .status, .reload
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [OFF_W-1:0] A_OFF = OFF_W'(2 * n);
    localparam logic [OFF_W-1:0] C_OFF = OFF_W'(2 * n + 1);
    dma_rb_chan u_chan (
      .clk, .rst_n,
      .we_addr  (bus_wr && bus_off == A_OFF),
      .we_cnt   (bus_wr && bus_off == C_OFF),
      .hi_sel   (ptr_hi),
      .wdata    (bus_wdata),
      .eng_ld   (eng_ld_valid && eng_ld_ch == CHW'(n)),
      .eng_addr (eng_ld_addr),
      .eng_cnt  (eng_ld_cnt),
      .reload   (reload[n]),
      .cur_addr (ca[n]),
      .cur_cnt  (cc[n])
    );
    assign cur_addr[n*VW +: VW] = ca[n];
    assign cur_cnt[n*VW +: VW]  = cc[n];
  end

  logic [VW-1:0] rd_val;
  always_comb begin
    rd_val = bus_off[0] ? cc[bus_off[CHW:1]] : ca[bus_off[CHW:1]];
    if (!bus_off[OFF_W-1])       bus_rdata = ptr_hi ? rd_val[VW-1:DW] : rd_val[DW-1:0];
    else if (bus_off == OFF_CMD) bus_rdata = status;
    else                         bus_rdata = '0;
  end
endmodule

// File: rtl/dma_rb_chk.sv
module dma_rb_chk
  import dma_rb_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [OFF_W-1:0]      bus_off,
  input logic [DW-1:0]         bus_wdata,
  input logic [NCH-1:0]        ch_mask,
  input logic [NCH*MODE_W-1:0] ch_mode,
  input logic [DW-1:0]         cmd_reg,
  input logic [NCH-1:0]        sw_req
);
  logic [CHW-1:0]    last_ch;
  logic [MODE_W-1:0] mode_sel;
  always_ff @(posedge clk) last_ch <= bus_wdata[CHW-1:0];
  assign mode_sel = ch_mode[last_ch*MODE_W +: MODE_W];

  p_single_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_off == OFF_SMASK |=> ch_mask[last_ch] == $past(bus_wdata[CHW]));
  p_all_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_off == OFF_AMASK |=> ch_mask == $past(bus_wdata[NCH-1:0]));
  p_clear_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_off == OFF_CLRMASK |=> ch_mask == '0);
  p_mode_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_off == OFF_MODE |=> mode_sel == $past(bus_wdata[DW-1:CHW]));
  p_cmd_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_off == OFF_CMD |=> cmd_reg == $past(bus_wdata));
  p_master_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_off == OFF_MCLR |=> ch_mask == '1 && cmd_reg == '0 && sw_req == '0);
endmodule

bind dma_regbank dma_rb_chk u_chk (
  .clk, .rst_n, .bus_wr, .bus_off, .bus_wdata,
  .ch_mask, .ch_mode, .cmd_reg, .sw_req
);

// File: tb/dma_regbank_tb.sv
module dma_regbank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_off = 0;
  logic [7:0]  bus_wdata = 0, bus_rdata;
  logic        eng_ld_valid = 0;
  logic [1:0]  eng_ld_ch = 0;
  logic [15:0] eng_ld_addr = 0, eng_ld_cnt = 0;
  logic [3:0]  eng_tc = 0, eng_dreq = 0;
  logic [3:0]  ch_mask, sw_req;
  logic [23:0] ch_mode;
  logic [7:0]  cmd_reg;
  logic [63:0] cur_addr, cur_cnt;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regbank u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1; bus_off = off;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic tc_pulse(input logic [3:0] v);
    @(negedge clk); eng_tc = v;
    @(negedge clk); eng_tc = 0;
  endtask

  task automatic eng_load(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    eng_ld_valid = 1; eng_ld_ch = ch; eng_ld_addr = a; eng_ld_cnt = c;
    @(negedge clk);
    eng_ld_valid = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(ch_mask == 4'hF, "R1 mask", ch_mask, 4'hF);
    chk(cmd_reg == 0 && sw_req == 0, "R1 cmd/req", {cmd_reg, sw_req}, 0);
    chk(ch_mode == 0 && cur_addr == 0 && cur_cnt == 0, "R1 mode/addr/cnt", ch_mode, 0);
    rd(4'h8, d);
    chk(d == 0, "R1 status", d, 0);
  endtask

  task automatic t_chan_regs();
    logic [7:0] d;
    wr(4'hC, 8'h5A);
    wr(4'h4, 8'h34); wr(4'h4, 8'h12);
    chk(cur_addr[32 +: 16] == 16'h1234, "R2 ch2 addr", cur_addr[32 +: 16], 16'h1234);
    wr(4'h3, 8'hFF); wr(4'h3, 8'h00);
    chk(cur_cnt[16 +: 16] == 16'h00FF, "R2 ch1 count", cur_cnt[16 +: 16], 16'h00FF);
    wr(4'hC, 8'h00);
    rd(4'h4, d); chk(d == 8'h34, "R3 read low first", d, 8'h34);
    rd(4'h4, d); chk(d == 8'h12, "R3 read high second", d, 8'h12);
  endtask

  task automatic t_ptr_clear();
    wr(4'hC, 0);
    wr(4'h0, 8'hAA);
    wr(4'hC, 8'hFF);
    wr(4'h0, 8'hBB);
    chk(cur_addr[0 +: 16] == 16'h00BB, "R3 clear redirects to low", cur_addr[0 +: 16], 16'h00BB);
    wr(4'h0, 8'hCC);
    chk(cur_addr[0 +: 16] == 16'hCCBB, "R3 toggles to high", cur_addr[0 +: 16], 16'hCCBB);
  endtask

  task automatic t_masks();
    wr(4'hE, 0);    chk(ch_mask == 0,    "R6 clear mask", ch_mask, 0);
    wr(4'hA, 8'h06); chk(ch_mask == 4'h4, "R5 mask ch2", ch_mask, 4'h4);
    wr(4'hA, 8'h03); chk(ch_mask == 4'h4, "R5 unmask ch3 no change", ch_mask, 4'h4);
    wr(4'hA, 8'h07); chk(ch_mask == 4'hC, "R5 mask ch3", ch_mask, 4'hC);
    wr(4'hA, 8'h02); chk(ch_mask == 4'h8, "R5 unmask ch2", ch_mask, 4'h8);
    wr(4'hF, 8'hFA); chk(ch_mask == 4'hA, "R6 all mask", ch_mask, 4'hA);
    wr(4'hE, 0);    chk(ch_mask == 0,    "R6 clear mask again", ch_mask, 0);
  endtask

  task automatic t_modes();
    wr(4'hB, 8'h45);
    chk(ch_mode[6 +: 6] == 6'h11, "R7 ch1 mode", ch_mode[6 +: 6], 6'h11);
    chk(ch_mode[0 +: 6] == 0, "R7 ch0 untouched", ch_mode[0 +: 6], 0);
    wr(4'hB, 8'hC2);
    chk(ch_mode[12 +: 6] == 6'h30, "R7 ch2 cascade mode", ch_mode[12 +: 6], 6'h30);
    chk(ch_mode[6 +: 6] == 6'h11, "R7 ch1 kept", ch_mode[6 +: 6], 6'h11);
  endtask

  task automatic t_cmd_misc();
    logic [7:0] d;
    wr(4'h8, 8'h08);
    chk(cmd_reg == 8'h08, "R8 command", cmd_reg, 8'h08);
    rd(4'hD, d); chk(d == 0, "R8 temp read", d, 0);
    rd(4'h9, d); chk(d == 0, "R8 write-only read 9", d, 0);
    rd(4'hF, d); chk(d == 0, "R8 write-only read F", d, 0);
  endtask

  task automatic t_status();
    logic [7:0] d;
    wr(4'h9, 8'h06);
    chk(sw_req == 4'h4, "R10 set request ch2", sw_req, 4'h4);
    eng_dreq = 4'h1;
    tc_pulse(4'h8);
    rd(4'h8, d); chk(d == 8'h58, "R9 status", d, 8'h58);
    rd(4'h8, d); chk(d == 8'h50, "R9 tc cleared by read", d, 8'h50);
    wr(4'h9, 8'h02);
    chk(sw_req == 0, "R10 clear request", sw_req, 0);
    eng_dreq = 0;
    rd(4'h8, d); chk(d == 0, "R9 status idle", d, 0);
  endtask

  task automatic t_engine();
    logic [7:0] d;
    wr(4'hB, 8'h50);
    eng_load(2'd0, 16'h2000, 16'h0010);
    chk(cur_addr[0 +: 16] == 16'h2000 && cur_cnt[0 +: 16] == 16'h0010, "R4 engine load ch0",
        {cur_addr[0 +: 16], cur_cnt[0 +: 16]}, 32'h20000010);
    wr(4'hC, 0);
    rd(4'h0, d); chk(d == 8'h00, "R2 read current low", d, 8'h00);
    rd(4'h0, d); chk(d == 8'h20, "R2 read current high", d, 8'h20);
    tc_pulse(4'h1);
    chk(cur_addr[0 +: 16] == 16'hCCBB && cur_cnt[0 +: 16] == 0, "R12 autoinit reload",
        {cur_addr[0 +: 16], cur_cnt[0 +: 16]}, 32'hCCBB0000);
    eng_load(2'd1, 16'h5555, 16'h0003);
    chk(cur_addr[16 +: 16] == 16'h5555, "R4 engine load ch1", cur_addr[16 +: 16], 16'h5555);
    tc_pulse(4'h2);
    chk(cur_addr[16 +: 16] == 16'h5555 && cur_cnt[16 +: 16] == 16'h0003, "R12 no reload without autoinit",
        {cur_addr[16 +: 16], cur_cnt[16 +: 16]}, 32'h55550003);
  endtask

  task automatic t_master_clear();
    logic [7:0] d;
    wr(4'hC, 0);
    wr(4'h2, 8'h77);
    chk(cur_addr[16 +: 16] == 16'h5577, "R2 low byte write", cur_addr[16 +: 16], 16'h5577);
    wr(4'h8, 8'h04);
    wr(4'h9, 8'h05);
    wr(4'hD, 8'h00);
    chk(ch_mask == 4'hF, "R11 masks set", ch_mask, 4'hF);
    chk(cmd_reg == 0 && sw_req == 0, "R11 cmd/req cleared", {cmd_reg, sw_req}, 0);
    rd(4'h8, d); chk(d == 0, "R11 tc cleared", d, 0);
    wr(4'h2, 8'h99);
    chk(cur_addr[16 +: 16] == 16'h5599, "R11 pointer back to low", cur_addr[16 +: 16], 16'h5599);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_chan_regs();
    t_ptr_clear();
    t_masks();
    t_modes();
    t_cmd_misc();
    t_status();
    t_engine();
    t_master_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule